// File: doc/BRIEF.md
# Multi-Source Interrupt Output Controller

This block merges three event sources (a watchdog timeout, an alarm match and a power-fail warning) into a single interrupt pin. Each event always latches its own status flag. An 8-bit control register decides which sources also drive the pin, whether an alarm may act while the part runs from its backup supply, how the pin is driven, and whether the pin gives a timed pulse or a level.

The pin is modelled as an output-enable and an output-data pair. In push-pull mode the pin is always driven and is high when active. In open-drain mode the data is always low and the enable is raised when the pin is active. In pulse mode each qualifying event starts or restarts a counter that runs from a slow input tick. The default of 7 ticks of a 32 Hz tick gives about 200 ms. In level mode the pin stays active until software reads the flags, which is marked by a one-cycle read strobe.

Top module: `intc_irq_out`

## Requirements
- R1: After reset the control register reads 0x00. A write stores bits 7..2 and bits 1..0 always read 0. The bit meanings are: 7 watchdog enable, 6 alarm enable, 5 power-fail enable, 4 alarm backup-supply enable, 3 active-high push-pull select, 2 pulse select.
- R2: A one-cycle event sets its flag on the next clock edge, whatever its enable bit is. The flag bits are: bit 0 watchdog, bit 1 alarm, bit 2 power-fail.
- R3: A read strobe clears all flags at the next edge. An event arriving in the same cycle as the strobe leaves its own flag set.
- R4: An event whose enable bit is 1 makes the pin active one edge later. An event whose enable bit is 0 leaves the pin unchanged.
- R5: While `on_battery` is 1 and control bit 4 is 0, an alarm event is ignored: it sets no flag and does not drive the pin.
- R6: With control bit 3 at 1, `irq_oe` is 1 and `irq_do` equals the active state.
- R7: With control bit 3 at 0, `irq_do` is 0 and `irq_oe` equals the active state.
- R8: In level mode (control bit 2 at 0), the pin stays active until the edge after a read strobe, unless a new enabled event arrives in that same cycle.
- R9: In pulse mode, the pin is active from the edge after an enabled event until PULSE_TICKS tick cycles have passed. A new event reloads the count. A read strobe does not shorten the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_q | output | 8 | Control register contents |
| wdog_evt | input | 1 | Watchdog timeout event, one cycle |
| alarm_evt | input | 1 | Alarm match event, one cycle |
| pfail_evt | input | 1 | Power-fail event, one cycle |
| on_battery | input | 1 | Supply is below the low threshold |
| flags_rd | input | 1 | Flags register read strobe |
| slow_tick | input | 1 | One-cycle tick of the slow time base |
| flags | output | 3 | Latched event flags |
| irq_oe | output | 1 | Interrupt pin output enable |
| irq_do | output | 1 | Interrupt pin output data |

## Verification
Flags, the control readback and the active state are all registered. Each of them is due exactly one edge after the input that changes it. The pin pair follows the control register in the same cycle that the register changes. A pulse falls on the edge of the PULSE_TICKS-th tick after its load. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It then compares every output against the model on the next falling edge, which is half a period after the rising edge on which both change.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int NUM_SRC = 3;
   localparam int SRC_WD  = 0;
   localparam int SRC_AL  = 1;
   localparam int SRC_PF  = 2;

   typedef struct packed {
      logic       wd_en;
      logic       al_en;
      logic       pf_en;
      logic       al_batt_en;
      logic       act_high;
      logic       pulse_mode;
      logic [1:0] rsvd;
   } intc_ctrl_t;
endpackage

// File: rtl/intc_ctrl_reg.sv
module intc_ctrl_reg
   import intc_pkg::*;
#(
   parameter logic [7:0] WRITE_MASK = 8'hFC
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wdata,
   output intc_ctrl_t ctrl
);
   logic [7:0] reg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  reg_q <= '0;
      else if (we) reg_q <= wdata & WRITE_MASK;
   end

   assign ctrl = intc_ctrl_t'(reg_q);

   a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (reg_q & ~WRITE_MASK) == 8'h00);
endmodule

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         rd,
   output logic [N-1:0] flag_q
);
   if (N < 1) begin : g_bad_n
      $error("intc_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag_q[i] <= 1'b0;
         else if (evt[i]) flag_q[i] <= 1'b1;
         else if (rd)     flag_q[i] <= 1'b0;
      end

      a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> flag_q[i]);
      a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (rd && !evt[i]) |=> !flag_q[i]);
   end
endmodule

// File: rtl/intc_pulse_timer.sv
module intc_pulse_timer #(
   parameter int PULSE_TICKS = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic tick,
   output logic busy
);
   localparam int CW = $clog2(PULSE_TICKS + 1);
   localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_TICKS);

   if (PULSE_TICKS < 1) begin : g_bad_ticks
      $error("intc_pulse_timer: PULSE_TICKS must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (load)                     cnt_q <= LOAD_VAL;
      else if (tick && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == LOAD_VAL);
   a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/intc_irq_out.sv
module intc_irq_out
   import intc_pkg::*;
#(
   parameter int PULSE_TICKS = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_we,
   input  logic [7:0] ctrl_wdata,
   output logic [7:0] ctrl_q,
   input  logic       wdog_evt,
   input  logic       alarm_evt,
   input  logic       pfail_evt,
   input  logic       on_battery,
   input  logic       flags_rd,
   input  logic       slow_tick,
   output logic [2:0] flags,
   output logic       irq_oe,
   output logic       irq_do
);
   intc_ctrl_t         ctrl;
   logic [NUM_SRC-1:0] evt_q;
   logic [NUM_SRC-1:0] en_vec;
   logic               fire;
   logic               lvl_q;
   logic               pulse_busy;
   logic               active;

   intc_ctrl_reg #(.WRITE_MASK(8'hFC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .ctrl(ctrl)
   );
   assign ctrl_q = ctrl;

   // Alarm is dropped entirely while on backup supply unless allowed.
   always_comb begin
      evt_q          = '0;
      evt_q[SRC_WD]  = wdog_evt;
      evt_q[SRC_AL]  = alarm_evt && (!on_battery || ctrl.al_batt_en);
      evt_q[SRC_PF]  = pfail_evt;
      en_vec         = '0;
      en_vec[SRC_WD] = ctrl.wd_en;
      en_vec[SRC_AL] = ctrl.al_en;
      en_vec[SRC_PF] = ctrl.pf_en;
   end

   assign fire = |(evt_q & en_vec);

   intc_flag_bank #(.N(NUM_SRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .evt(evt_q), .rd(flags_rd), .flag_q(flags)
   );

   intc_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
      .clk(clk), .rst_n(rst_n), .load(fire && ctrl.pulse_mode),
      .tick(slow_tick), .busy(pulse_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         lvl_q <= 1'b0;
      else if (fire && !ctrl.pulse_mode)  lvl_q <= 1'b1;
      else if (flags_rd)                  lvl_q <= 1'b0;
   end

   assign active = ctrl.pulse_mode ? pulse_busy : lvl_q;
   assign irq_oe = ctrl.act_high ? 1'b1 : active;
   assign irq_do = ctrl.act_high ? active : 1'b0;

   a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q && !flags_rd) |=> lvl_q);
   a_r5_alarm_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (on_battery && !ctrl.al_batt_en && alarm_evt && !flags[SRC_AL])
      |=> !flags[SRC_AL]);
   a_r4_enabled_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (pfail_evt && ctrl.pf_en && !ctrl_we) |=> active);
   a_r7_od_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.act_high |-> !irq_do);
endmodule

// File: tb/tb_intc_irq_out.sv
module tb_intc_irq_out;
   localparam int CLK_PERIOD = 10;
   localparam int PT = 7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ctrl_we = 0, wdog_evt = 0, alarm_evt = 0, pfail_evt = 0;
   logic on_battery = 0, flags_rd = 0, slow_tick = 0;
   logic [7:0] ctrl_wdata = 0;
   logic [7:0] ctrl_q;
   logic [2:0] flags;
   logic irq_oe, irq_do;

   int checks = 0, failures = 0;
   bit done = 0;

   // reference model state
   int m_ctrl = 0, m_flags = 0, m_lvl = 0, m_cnt = 0;

   intc_irq_out #(.PULSE_TICKS(PT)) dut (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .ctrl_q(ctrl_q), .wdog_evt(wdog_evt), .alarm_evt(alarm_evt),
      .pfail_evt(pfail_evt), .on_battery(on_battery), .flags_rd(flags_rd),
      .slow_tick(slow_tick), .flags(flags), .irq_oe(irq_oe), .irq_do(irq_do)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 0; m_flags = 0; m_lvl = 0; m_cnt = 0;
      end else begin
         int ev, fire, al_ok;
         al_ok = (alarm_evt && (!on_battery || m_ctrl[4])) ? 1 : 0;
         ev = (wdog_evt ? 1 : 0) | (al_ok << 1) | ((pfail_evt ? 1 : 0) << 2);
         fire = ((ev & 1) && m_ctrl[7]) || ((ev & 2) && m_ctrl[6]) ||
                ((ev & 4) && m_ctrl[5]) ? 1 : 0;
         m_flags = flags_rd ? ev : (m_flags | ev);
         if (fire && !m_ctrl[2]) m_lvl = 1;
         else if (flags_rd) m_lvl = 0;
         if (fire && m_ctrl[2]) m_cnt = PT;
         else if (slow_tick && m_cnt > 0) m_cnt = m_cnt - 1;
         if (ctrl_we) m_ctrl = ctrl_wdata & 8'hFC;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every cycle on the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int act_m;
         act_m = m_ctrl[2] ? (m_cnt > 0) : m_lvl;
         check("R1 ctrl_q", ctrl_q, m_ctrl);
         check("R2/R3/R5 flags", flags, m_flags);
         if (m_ctrl[3]) begin
            check("R6 irq_oe", irq_oe, 1);
            check("R6/R4/R8/R9 irq_do", irq_do, act_m);
         end else begin
            check("R7/R4/R8/R9 irq_oe", irq_oe, act_m);
            check("R7 irq_do", irq_do, 0);
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ctrl_we = 0; wdog_evt = 0; alarm_evt = 0; pfail_evt = 0;
         flags_rd = 0; slow_tick = 0;
      end
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
      @(negedge clk); ctrl_we = 0;
   endtask

   task automatic pulse_in(input bit wd, input bit al, input bit pf, input bit rd);
      @(negedge clk);
      wdog_evt = wd; alarm_evt = al; pfail_evt = pf; flags_rd = rd;
      @(negedge clk);
      wdog_evt = 0; alarm_evt = 0; pfail_evt = 0; flags_rd = 0;
   endtask

   task automatic tick_run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); slow_tick = 1;
         @(negedge clk); slow_tick = 0;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      // R1 reset state
      check("R1 reset ctrl", ctrl_q, 0);
      check("R2 reset flags", flags, 0);
      check("R7 reset idle oe", irq_oe, 0);
      wr(8'hFF); #1; check("R1 reserved bits read 0", ctrl_q, 8'hFC);
      // R2/R4 disabled sources set only flags
      wr(8'h00);
      pulse_in(1, 0, 0, 0); #1;
      check("R2 wdog flag", flags, 1);
      check("R4 disabled no pin", irq_oe, 0);
      pulse_in(0, 1, 1, 1); #1;
      check("R3 event wins read", flags, 6);
      pulse_in(0, 0, 0, 1); #1;
      check("R3 read clears", flags, 0);
      // R6/R8 push-pull level
      wr(8'hE8);
      pulse_in(0, 0, 1, 0); idle(5); #1;
      check("R8 level held", irq_do, 1);
      pulse_in(0, 0, 0, 1); #1;
      check("R8 released by read", irq_do, 0);
      // R5 battery gating
      on_battery = 1;
      pulse_in(0, 1, 0, 0); #1;
      check("R5 alarm ignored flag", flags, 0);
      check("R5 alarm ignored pin", irq_do, 0);
      wr(8'hF8);
      pulse_in(0, 1, 0, 0); #1;
      check("R5 alarm allowed", flags, 2);
      on_battery = 0;
      pulse_in(0, 0, 0, 1);
      // R7 open drain level
      wr(8'hE0);
      pulse_in(1, 0, 0, 0); #1;
      check("R7 od active oe", irq_oe, 1);
      check("R7 od data low", irq_do, 0);
      pulse_in(0, 0, 0, 1);
      // R9 pulse mode, active high
      wr(8'hEC);
      pulse_in(1, 0, 0, 0);
      tick_run(3);
      pulse_in(0, 0, 0, 1); #1;
      check("R9 read does not end pulse", irq_do, 1);
      pulse_in(0, 0, 1, 0);
      tick_run(PT - 1); #1;
      check("R9 retrigger extends", irq_do, 1);
      tick_run(1); #1;
      check("R9 pulse ends", irq_do, 0);
      // random phase
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         ctrl_we    = ($urandom_range(0, 40) == 0);
         ctrl_wdata = 8'($urandom);
         wdog_evt   = ($urandom_range(0, 15) == 0);
         alarm_evt  = ($urandom_range(0, 15) == 0);
         pfail_evt  = ($urandom_range(0, 15) == 0);
         on_battery = ($urandom_range(0, 3) == 0);
         flags_rd   = ($urandom_range(0, 10) == 0);
         slow_tick  = ($urandom_range(0, 4) == 0);
      end
      idle(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule